// File: doc/BRIEF.md
# Rotate and Mask Insert Unit

This block rotates a 32-bit operand to the left and then shapes the rotated word with a mask built from two bit positions. The mask is a run of ones from a begin position to an end position. Bit positions are numbered from the most significant end. When the begin position lies past the end position, the run wraps around the top of the word. One rotator and one mask generator serve two result modes. AND mode keeps only the rotated bits under the mask and clears every other bit. Insert mode writes the rotated bits under the mask into a copy of the current target value and leaves the target's other bits as they were.

The rotate amount comes either from a 5-bit immediate or from the low five bits of a second register operand. When the record flag is set, the unit also produces a four-bit condition summary of the final result. The result and the summary are registered together with a valid flag, so a result appears one cycle after its operation is presented. An issue stage drives one operation per cycle with `in_valid`. The write-back stage takes `out_result` and, for recorded operations, `out_cond`.

Top module: `rotmask_unit`

## Requirements
- R1: The operand is rotated left by an amount from 0 to 31. Bits shifted out at the top re-enter at the bottom. An amount of 0 leaves the operand unchanged.
- R2: With `in_amt_sel` = 0 the amount is `in_amt_imm`. With `in_amt_sel` = 1 the amount is `in_amt_reg[4:0]`, and bits 31:5 of `in_amt_reg` have no effect.
- R3: Mask position p counts from the most significant end, so position p is vector bit 31-p. When begin <= end, the mask holds ones at positions begin through end inclusive and zeros at every other position.
- R4: When begin > end, the mask wraps. It holds ones at positions begin through 31 and at positions 0 through end, and zeros at every other position. The mask is therefore never all zeros.
- R5: With `in_mode` = 0 (AND mode), the result is the rotated value ANDed with the mask, so every bit outside the mask is 0.
- R6: With `in_mode` = 1 (insert mode), each result bit under the mask takes the rotated bit. Each other result bit takes the matching bit of `in_target`.
- R7: `out_valid` is `in_valid` delayed by exactly one clock. A result appears on `out_result` one clock after its operation is presented.
- R8: When `in_record` = 1, `out_cond` is {LT, GT, EQ, SO} in bits 3 down to 0. LT is set when result bit 31 is 1. GT is set when the result is nonzero and bit 31 is 0. EQ is set when the result is zero. SO is a copy of `in_so`. When `in_record` = 0, `out_cond` is 4'b0000.
- R9: While `rst_n` is low, `out_valid`, `out_result` and `out_cond` are all 0.
- R10: In a cycle where `in_valid` is 0, `out_result` and `out_cond` keep their previous values whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| in_valid | input | 1 | An operation is presented this cycle |
| in_src | input | 32 | Operand to rotate |
| in_amt_reg | input | 32 | Register operand; its low 5 bits can give the amount |
| in_amt_imm | input | 5 | Immediate rotate amount |
| in_amt_sel | input | 1 | Amount source: 0 immediate, 1 register |
| in_mb | input | 5 | Mask begin position (0 = most significant bit) |
| in_me | input | 5 | Mask end position (0 = most significant bit) |
| in_target | input | 32 | Current target value, used in insert mode |
| in_mode | input | 1 | 0 AND mode, 1 insert mode |
| in_record | input | 1 | Produce the condition summary |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Rotated and masked result |
| out_cond | output | 4 | {LT, GT, EQ, SO}, or zero when not recorded |

## Verification
Several properties are checked on every cycle:
- A zero amount passes the operand through the rotator.
- The number of mask ones matches the begin/end distance, including the wrapped case.
- AND-mode results have no bits set outside the previous cycle's mask.
- Insert-mode results match the old target outside that mask.
- Exactly one of LT, GT and EQ is set for a recorded operation.
- The valid flag is delayed by exactly one cycle.
- Results stay fixed in idle cycles.

Other behaviour needs the bench's scenarios. These include the exact bit placement of the rotation, and which amount source is selected. They also include the correct values under the mask. The bench sweeps every begin/end pair against an independent model and adds directed cases for a zero amount, a full mask, single-bit masks and a register amount with its upper bits set.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    localparam int unsigned RM_WIDTH = 32;

    typedef enum logic {
        MODE_AND    = 1'b0,
        MODE_INSERT = 1'b1
    } rm_mode_e;

    typedef enum logic {
        AMT_IMM = 1'b0,
        AMT_REG = 1'b1
    } rm_amt_src_e;

    // condition field bit positions
    localparam int unsigned COND_LT = 3;
    localparam int unsigned COND_GT = 2;
    localparam int unsigned COND_EQ = 1;
    localparam int unsigned COND_SO = 0;
    localparam int unsigned COND_W  = 4;

endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [AW+1];

    assign stage[0] = din;

    // logarithmic barrel: stage s rotates by 2**s when amt[s] is set
    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned SH = 1 << s;
        logic [W-1:0] rot_s;
        assign rot_s = {stage[s][W-1-SH:0], stage[s][W-1:W-SH]};
        assign stage[s+1] = amt[s] ? rot_s : stage[s];
    end

    assign dout = stage[AW];

    always_comb begin
        if (amt == '0) begin
            a_r1_zero_passes: assert (dout == din)
                else $error("R1: zero rotate altered operand");
        end
    end

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [AW-1:0] mb,
    input  logic [AW-1:0] me,
    output logic [W-1:0]  mask
);

    logic wrap;
    assign wrap = (mb > me);

    // position p counts from the most significant bit
    for (genvar p = 0; p < W; p++) begin : g_pos
        logic ge_b;
        logic le_e;
        assign ge_b = (AW'(p) >= mb);
        assign le_e = (AW'(p) <= me);
        assign mask[W-1-p] = wrap ? (ge_b | le_e) : (ge_b & le_e);
    end

    always_comb begin
        if (!wrap) begin
            a_r3_run_length: assert ($countones(mask) == (int'(me) - int'(mb) + 1))
                else $error("R3: mask length mismatch");
        end else begin
            a_r4_wrap_length: assert ($countones(mask) == (int'(W) - (int'(mb) - int'(me) - 1)))
                else $error("R4: wrapped mask length mismatch");
        end
    end

endmodule

// File: rtl/rotmask_cond.sv
module rotmask_cond #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]                   value,
    input  logic                           record,
    input  logic                           so,
    output logic [rotmask_pkg::COND_W-1:0] cond
);
    import rotmask_pkg::*;

    always_comb begin
        cond = '0;
        if (record) begin
            cond[COND_LT] = value[W-1];
            cond[COND_GT] = !value[W-1] && (value != '0);
            cond[COND_EQ] = (value == '0);
            cond[COND_SO] = so;
        end
    end

    always_comb begin
        if (record) begin
            a_r8_one_relation: assert ($countones(cond[COND_LT:COND_EQ]) == 1)
                else $error("R8: condition relation not one-hot");
        end
    end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
    parameter int unsigned DATA_W = rotmask_pkg::RM_WIDTH,
    localparam int unsigned AW    = $clog2(DATA_W),
    localparam int unsigned CW    = rotmask_pkg::COND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_amt_reg,
    input  logic [AW-1:0]     in_amt_imm,
    input  logic              in_amt_sel,
    input  logic [AW-1:0]     in_mb,
    input  logic [AW-1:0]     in_me,
    input  logic [DATA_W-1:0] in_target,
    input  logic              in_mode,
    input  logic              in_record,
    input  logic              in_so,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [CW-1:0]     out_cond
);
    import rotmask_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [CW-1:0]     cond;
    } rm_state_t;

    rm_state_t st_d, st_q;

    logic [AW-1:0]     amt_w;
    logic [DATA_W-1:0] rot_w;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] merged_w;
    logic [CW-1:0]     cond_w;

    assign amt_w = (rm_amt_src_e'(in_amt_sel) == AMT_REG) ? in_amt_reg[AW-1:0] : in_amt_imm;

    rotmask_rotator #(.W(DATA_W), .AW(AW)) u_rot (
        .din  (in_src),
        .amt  (amt_w),
        .dout (rot_w)
    );

    rotmask_maskgen #(.W(DATA_W), .AW(AW)) u_mask (
        .mb   (in_mb),
        .me   (in_me),
        .mask (mask_w)
    );

    always_comb begin
        if (rm_mode_e'(in_mode) == MODE_INSERT) begin
            merged_w = (rot_w & mask_w) | (in_target & ~mask_w);
        end else begin
            merged_w = rot_w & mask_w;
        end
    end

    rotmask_cond #(.W(DATA_W)) u_cond (
        .value  (merged_w),
        .record (in_record),
        .so     (in_so),
        .cond   (cond_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = merged_w;
            st_d.cond   = cond_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_cond   = st_q.cond;

    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)))
        else $error("R7: valid not delayed by one cycle");

    a_r5_and_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode) |=> ((out_result & ~$past(mask_w)) == '0))
        else $error("R5: bit set outside mask in AND mode");

    a_r6_insert_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode) |=> (((out_result ^ $past(in_target)) & ~$past(mask_w)) == '0))
        else $error("R6: target bit lost outside mask");

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_cond)))
        else $error("R10: output changed in idle cycle");

endmodule

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_src, in_amt_reg, in_target;
    logic [4:0]  in_amt_imm, in_mb, in_me;
    logic        in_amt_sel, in_mode, in_record, in_so;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_cond;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rotmask_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_amt_reg(in_amt_reg), .in_amt_imm(in_amt_imm), .in_amt_sel(in_amt_sel),
        .in_mb(in_mb), .in_me(in_me), .in_target(in_target), .in_mode(in_mode),
        .in_record(in_record), .in_so(in_so), .out_valid(out_valid),
        .out_result(out_result), .out_cond(out_cond)
    );

    function automatic logic [31:0] ref_rotl(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int k = 0; k < n; k++) r = {r[30:0], r[31]};
        return r;
    endfunction

    function automatic logic [31:0] ref_mask(input int b, input int e);
        logic [31:0] m = '0;
        for (int p = 0; p < 32; p++) begin
            if (b <= e) m[31-p] = (p >= b && p <= e);
            else        m[31-p] = (p >= b || p <= e);
        end
        return m;
    endfunction

    function automatic logic [3:0] ref_cond(input logic [31:0] v, input logic rec, input logic so);
        if (!rec) return 4'b0000;
        if (v == 0)     return {3'b001, so};
        else if (v[31]) return {3'b100, so};
        else            return {3'b010, so};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one op at negedge, check at the following negedge
    task automatic run_op(input string req, input logic [31:0] src, input logic [31:0] areg,
                          input logic [4:0] aimm, input logic asel, input logic [4:0] mb,
                          input logic [4:0] me, input logic [31:0] tgt, input logic mode,
                          input logic rec, input logic so);
        int n;
        logic [31:0] m, exp_r;
        @(negedge clk);
        in_valid = 1; in_src = src; in_amt_reg = areg; in_amt_imm = aimm;
        in_amt_sel = asel; in_mb = mb; in_me = me; in_target = tgt;
        in_mode = mode; in_record = rec; in_so = so;
        n = asel ? int'(areg[4:0]) : int'(aimm);
        m = ref_mask(int'(mb), int'(me));
        exp_r = mode ? ((ref_rotl(src, n) & m) | (tgt & ~m)) : (ref_rotl(src, n) & m);
        @(negedge clk);
        in_valid = 0;
        check({req, " R7 valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " result"}, out_result, exp_r);
        check({req, " R8 cond"}, {28'b0, out_cond}, {28'b0, ref_cond(exp_r, rec, so)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_r;
        logic [3:0]  hold_c;
        void'($urandom(32'h5eed_1234));
        rst_n = 0; in_valid = 0; in_src = '0; in_amt_reg = '0; in_amt_imm = '0;
        in_amt_sel = 0; in_mb = '0; in_me = '0; in_target = '0; in_mode = 0;
        in_record = 0; in_so = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 valid", {31'b0, out_valid}, 32'd0);
        check("R9 result", out_result, 32'd0);
        check("R9 cond", {28'b0, out_cond}, 32'd0);
        rst_n = 1;

        // R1 zero amount, full mask
        run_op("R1 zero", 32'hDEAD_BEEF, 32'h0, 5'd0, 0, 5'd0, 5'd31, 32'h0, 0, 1, 0);
        // R1 rotate by 8
        run_op("R1 rot8", 32'h1234_5678, 32'h0, 5'd8, 0, 5'd0, 5'd31, 32'h0, 0, 1, 1);
        // R2 register amount, upper bits set (amount 4)
        run_op("R2 reg", 32'h8000_0001, 32'hFFFF_FFE4, 5'd17, 1, 5'd0, 5'd31, 32'h0, 0, 0, 0);
        // R3 single bit at position 0 (msb)
        run_op("R3 single", 32'hFFFF_FFFF, 32'h0, 5'd0, 0, 5'd0, 5'd0, 32'h0, 0, 1, 0);
        // R4 wrap: begin = end+1 gives all ones
        run_op("R4 allones", 32'hA5A5_0F0F, 32'h0, 5'd3, 0, 5'd10, 5'd9, 32'h0, 0, 1, 0);
        // R5 AND yields zero -> EQ
        run_op("R5 zero", 32'h0000_00FF, 32'h0, 5'd0, 0, 5'd0, 5'd7, 32'hFFFF_FFFF, 0, 1, 1);
        // R6 insert single bit at lsb position 31
        run_op("R6 insert", 32'h0000_0001, 32'h0, 5'd0, 0, 5'd31, 5'd31, 32'h1234_5670, 1, 1, 0);

        // R10 idle hold with changing inputs
        hold_r = out_result; hold_c = out_cond;
        @(negedge clk);
        in_src = 32'hFFFF_FFFF; in_target = 32'h5555_5555; in_mode = 1; in_record = 1; in_so = 1;
        @(negedge clk);
        check("R10 result", out_result, hold_r);
        check("R10 cond", {28'b0, out_cond}, {28'b0, hold_c});

        // sweep all begin/end pairs, random data, both modes
        for (int b = 0; b < 32; b++) begin
            for (int e = 0; e < 32; e++) begin
                logic asel;
                asel = 1'($urandom());
                run_op((b <= e) ? "R3/R5/R6 sweep" : "R4/R5/R6 sweep",
                       $urandom(), $urandom(), 5'($urandom()), asel, 5'(b), 5'(e),
                       $urandom(), 1'($urandom()), 1'($urandom()), 1'($urandom()));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule